// File: doc/BRIEF.md
# Serial Flash Controller Interrupt Status and Gating Unit

This unit gathers the interrupt sources of a serial flash controller into a single line. Level conditions are derived from the transmit and receive FIFO occupancy counts: empty, full, and a programmable threshold. Event pulses come from the descriptor engine: descriptor done, packet complete and DMA error. A source is captured into a sticky status register only while its enable bit is set. The interrupt line is then gated a second time by a signal-enable mask.

Software acknowledges a source by clearing its enable bit, which also drops the latched status. A status read of all zeros means nothing is pending. After reset every enable and signal-enable bit is zero, so the interrupt a soft reset raises stays hidden until software opts in. A small register port, one word per address, reaches the enable, status, signal-enable and threshold words.

Top module: `sfc_irq_ctrl`

## Requirements
- R1: After reset the enable, status, signal-enable and threshold words read zero and irq_o is low.
- R2: Status, enable and signal-enable share one layout: tx empty bit 0, tx full bit 1, tx threshold bit 2, rx empty bit 3, rx full bit 4, rx threshold bit 5, descriptor done bit 9, packet complete bit 10, DMA error bit 11. Enable and signal-enable keep only those bits (write all ones, read 0x00000E3F). The threshold word keeps tx threshold at bits 12:8 and rx threshold at bits 4:0 (write all ones, read 0x00001F1F). Other bits read zero.
- R3: A status bit is set on the clock edge at which its source is active and its enable bit is already set; a source whose enable bit is clear leaves its status bit at zero.
- R4: A set status bit stays set after its source goes away, for as long as its enable bit stays set.
- R5: Writing a zero into an enable bit clears the matching status bit on the same clock edge that updates the enable word.
- R6: Tx empty is active when the tx count is 0, tx full when it equals the FIFO depth (16 by default), and tx threshold when depth minus count is at least the tx threshold.
- R7: Rx empty is active when the rx count is 0, rx full when it equals the FIFO depth, and rx threshold when the count is at least the rx threshold.
- R8: irq_o is registered. It equals, one clock later, the OR over all bits of status AND enable AND signal-enable.
- R9: Writes to the status address have no effect on any register.
- R10: Single-cycle pulses on desc_done_i, pkt_done_i and dma_err_i latch into bits 9, 10 and 11.

Register addresses: 0 enable, 1 status, 2 signal-enable, 3 threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word, combinational |
| tx_level_i | input | CNT_W (5) | Transmit FIFO occupancy |
| rx_level_i | input | CNT_W (5) | Receive FIFO occupancy |
| desc_done_i | input | 1 | Descriptor finished pulse |
| pkt_done_i | input | 1 | Packet finished pulse |
| dma_err_i | input | 1 | DMA error pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
The level conditions are swept over every FIFO count from 0 to the depth, crossed with every 5-bit threshold. This separates an off-by-one in the free-space or occupancy comparison from a swapped tx/rx field. Pulses are issued with the matching enable bit clear and then set, to check the latch gating. Pulses are also issued one source at a time, to check the bit mapping. The line is checked with the signal-enable mask both covering and excluding the pending bit. It is checked on the first cycle after a change and on the cycle after that, which exposes a line that is not registered or not gated.

// File: rtl/sfc_irq_pkg.sv
package sfc_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int NSRC   = 12;
  localparam int THR_W  = 5;

  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_FULL  = 1;
  localparam int B_TX_THR   = 2;
  localparam int B_RX_EMPTY = 3;
  localparam int B_RX_FULL  = 4;
  localparam int B_RX_THR   = 5;
  localparam int B_DESC     = 9;
  localparam int B_PKT      = 10;
  localparam int B_DMA_ERR  = 11;

  localparam logic [NSRC-1:0] SRC_MASK = 12'hE3F;

  localparam int TX_THR_LSB = 8;
  localparam int RX_THR_LSB = 0;

  localparam logic [ADDR_W-1:0] A_EN   = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_SIG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_THR  = 2'd3;

  typedef struct packed {
    logic [THR_W-1:0] tx;
    logic [THR_W-1:0] rx;
  } thr_t;
endpackage

// File: rtl/sfc_irq_regs.sv
module sfc_irq_regs
  import sfc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   stat_i,
  output logic [NSRC-1:0]   en_q_o,
  output logic [NSRC-1:0]   en_d_o,
  output logic [NSRC-1:0]   sig_q_o,
  output thr_t              thr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NSRC-1:0] en_q, sig_q, sig_d;
  thr_t thr_q, thr_d;
  logic unused_w;

  assign unused_w = ^wdata_i[DATA_W-1:TX_THR_LSB+THR_W];

  always_comb begin
    en_d_o = en_q;
    sig_d  = sig_q;
    thr_d  = thr_q;
    if (we_i) begin
      unique case (addr_i)
        A_EN:  en_d_o = wdata_i[NSRC-1:0] & SRC_MASK;
        A_SIG: sig_d  = wdata_i[NSRC-1:0] & SRC_MASK;
        A_THR: begin
          thr_d.tx = wdata_i[TX_THR_LSB +: THR_W];
          thr_d.rx = wdata_i[RX_THR_LSB +: THR_W];
        end
        default: ; // status is read-only
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sig_q <= '0;
      thr_q <= '0;
    end else begin
      en_q  <= en_d_o;
      sig_q <= sig_d;
      thr_q <= thr_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_EN:   rdata_o[NSRC-1:0] = en_q;
      A_STAT: rdata_o[NSRC-1:0] = stat_i;
      A_SIG:  rdata_o[NSRC-1:0] = sig_q;
      default: begin
        rdata_o[TX_THR_LSB +: THR_W] = thr_q.tx;
        rdata_o[RX_THR_LSB +: THR_W] = thr_q.rx;
      end
    endcase
  end

  assign en_q_o  = en_q;
  assign sig_q_o = sig_q;
  assign thr_o   = thr_q;
endmodule

// File: rtl/sfc_irq_src.sv
module sfc_irq_src
  import sfc_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic [CNT_W-1:0] rx_level_i,
  input  thr_t             thr_i,
  input  logic             desc_done_i,
  input  logic             pkt_done_i,
  input  logic             dma_err_i,
  output logic [NSRC-1:0]  src_o
);
  localparam int CW = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

  logic [CW-1:0] tx_free, tx_cnt, rx_cnt, tx_thr, rx_thr;

  assign tx_cnt  = CW'(tx_level_i);
  assign rx_cnt  = CW'(rx_level_i);
  assign tx_thr  = CW'(thr_i.tx);
  assign rx_thr  = CW'(thr_i.rx);
  assign tx_free = CW'(FIFO_DEPTH) - tx_cnt;

  always_comb begin
    src_o             = '0;
    src_o[B_TX_EMPTY] = (tx_cnt == '0);
    src_o[B_TX_FULL]  = (tx_cnt == CW'(FIFO_DEPTH));
    src_o[B_TX_THR]   = (tx_free >= tx_thr);
    src_o[B_RX_EMPTY] = (rx_cnt == '0);
    src_o[B_RX_FULL]  = (rx_cnt == CW'(FIFO_DEPTH));
    src_o[B_RX_THR]   = (rx_cnt >= rx_thr);
    src_o[B_DESC]     = desc_done_i;
    src_o[B_PKT]      = pkt_done_i;
    src_o[B_DMA_ERR]  = dma_err_i;
  end
endmodule

// File: rtl/sfc_irq_status.sv
module sfc_irq_status
  import sfc_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_q_i,
  input  logic [NSRC-1:0] en_d_i,
  input  logic [NSRC-1:0] sig_q_i,
  output logic [NSRC-1:0] stat_o,
  output logic            irq_o
);
  logic unused_w;
  assign unused_w = ^{src_i & ~SRC_MASK, en_d_i & ~SRC_MASK};

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_live
      logic st_q;
      // latch needs the old enable, clear follows the new one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= 1'b0;
        else         st_q <= (st_q | (src_i[i] & en_q_i[i])) & en_d_i[i];
      end
      assign stat_o[i] = st_q;
    end else begin : g_rsvd
      assign stat_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_o & en_q_i & sig_q_i);
  end
endmodule

// File: rtl/sfc_irq_ctrl.sv
module sfc_irq_ctrl
  import sfc_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  tx_level_i,
  input  logic [CNT_W-1:0]  rx_level_i,
  input  logic              desc_done_i,
  input  logic              pkt_done_i,
  input  logic              dma_err_i,
  output logic              irq_o
);
  logic [NSRC-1:0] en_w, en_d_w, sig_w, stat_w, src_w;
  thr_t            thr_w;

  sfc_irq_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .stat_i  (stat_w),
    .en_q_o  (en_w),
    .en_d_o  (en_d_w),
    .sig_q_o (sig_w),
    .thr_o   (thr_w),
    .rdata_o (rdata_o)
  );

  sfc_irq_src #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_src (
    .tx_level_i  (tx_level_i),
    .rx_level_i  (rx_level_i),
    .thr_i       (thr_w),
    .desc_done_i (desc_done_i),
    .pkt_done_i  (pkt_done_i),
    .dma_err_i   (dma_err_i),
    .src_o       (src_w)
  );

  sfc_irq_status i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_w),
    .en_q_i  (en_w),
    .en_d_i  (en_d_w),
    .sig_q_i (sig_w),
    .stat_o  (stat_w),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/sfc_irq_ctrl_chk.sv
module sfc_irq_ctrl_chk
  import sfc_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NSRC-1:0]   en_i,
  input logic [NSRC-1:0]   sig_i,
  input logic [NSRC-1:0]   stat_i,
  input logic              irq_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_i | sig_i | stat_i) & ~SRC_MASK) == '0); // R2

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_i) & en_i & ~stat_i) == '0)); // R4

  AST_STAT_UNDER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i & ~en_i) == '0); // R5

  AST_EN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN) |=> ((stat_i & ~$past(wdata_i[NSRC-1:0])) == '0)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == |($past(stat_i & en_i & sig_i))); // R8
endmodule

bind sfc_irq_ctrl sfc_irq_ctrl_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_i    (en_w),
  .sig_i   (sig_w),
  .stat_i  (stat_w),
  .irq_i   (irq_o)
);

// File: tb/test_sfc_irq_ctrl.sv
`timescale 1ns/1ps
module test_sfc_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata, v;
  logic [CW-1:0] tx_level, rx_level;
  logic        desc_done, pkt_done, dma_err, irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sfc_irq_ctrl #(.FIFO_DEPTH(DEPTH)) i_sfc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .desc_done_i(desc_done), .pkt_done_i(pkt_done), .dma_err_i(dma_err),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    tx_level = 8; rx_level = 8;
    desc_done = 0; pkt_done = 0; dma_err = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset word", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 layout and reserved bits
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 enable mask", v, 32'h0000_0E3F);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R2 sig mask", v, 32'h0000_0E3F);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R2 thr fields", v, 32'h0000_1F1F);
    wr(2'd0, 32'h0); wr(2'd2, 32'h0);
    // thresholds 31/31, levels 8: no level source active

    // R3 disabled source does not latch
    desc_done = 1; step(); desc_done = 0;
    rd(2'd1, v); chk("R3 disabled no latch", v, 32'h0);

    // R3 enabled source latches; pkt not enabled
    wr(2'd0, 32'h200);
    desc_done = 1; pkt_done = 1; step(); desc_done = 0; pkt_done = 0;
    rd(2'd1, v); chk("R3 latch enabled only", v, 32'h200);
    chk("R8 sig clear no irq", {31'b0, irq}, 32'h0);

    // R4 sticky
    repeat (5) step();
    rd(2'd1, v); chk("R4 sticky", v, 32'h200);

    // R8 registered gating
    wr(2'd2, 32'h200);
    chk("R8 irq one cycle late", {31'b0, irq}, 32'h0);
    step();
    chk("R8 irq asserted", {31'b0, irq}, 32'h1);

    // R9 status writes ignored
    wr(2'd1, 32'h0); rd(2'd1, v); chk("R9 status write 0 ignored", v, 32'h200);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R9 status write 1s ignored", v, 32'h200);
    rd(2'd0, v); chk("R9 enable untouched", v, 32'h200);
    rd(2'd2, v); chk("R9 sig untouched", v, 32'h200);

    // R5 clear by masking enable
    wr(2'd0, 32'h0); rd(2'd1, v); chk("R5 cleared same edge", v, 32'h0);
    step(); chk("R5 irq drops", {31'b0, irq}, 32'h0);

    // R10 event mapping, R8 gating per bit
    wr(2'd0, 32'hE00); wr(2'd2, 32'h800);
    dma_err = 1; step(); dma_err = 0;
    rd(2'd1, v); chk("R10 dma error bit 11", v, 32'h800);
    step(); chk("R8 irq on gated error", {31'b0, irq}, 32'h1);
    pkt_done = 1; step(); pkt_done = 0;
    rd(2'd1, v); chk("R10 packet bit 10", v, 32'hC00);
    desc_done = 1; step(); desc_done = 0;
    rd(2'd1, v); chk("R10 descriptor bit 9", v, 32'hE00);
    wr(2'd0, 32'h600); // drop error source
    rd(2'd1, v); chk("R5 partial clear", v, 32'h600);
    step(); step(); chk("R8 ungated bits no irq", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0); wr(2'd2, 32'h0);

    // R6 / R7 sweep of levels against thresholds
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t < 32; t++) begin
        logic [31:0] etx, erx;
        wr(2'd0, 32'h0);
        tx_level = CW'(c); rx_level = CW'(c);
        wr(2'd3, (32'(t) << 8) | 32'(t));
        wr(2'd0, 32'h3F);
        step();
        rd(2'd1, v);
        etx = {29'b0, ((DEPTH - c) >= t), (c == DEPTH), (c == 0)};
        erx = {29'b0, (c >= t), (c == DEPTH), (c == 0)};
        chk("R6 tx conditions", v & 32'h7, etx);
        chk("R7 rx conditions", (v >> 3) & 32'h7, erx);
      end
    end
    wr(2'd0, 32'h0);
    finish_run();
  end
endmodule